// File: doc/BRIEF.md
# Serial-In Latched Output Register

This block converts a serial bit stream into eight parallel current-sink enables. Serial data is taken on every rising edge of a shift clock. Each new bit enters the first stage, and the stored bits move one stage toward the serial output. That output is the last stage, so a second block can be chained behind this one to add drive lines. A level-sensitive strobe copies the register into an output latch, and the sink enables are driven from that latch.

The block runs on one system clock. The shift clock and the strobe arrive from outside and pass through a two-flop synchronizer. The rising edge of the shift clock is then found by comparing the synchronized level with its value one cycle earlier. Clear acts like data: while it is high, zeros are shifted in, and nothing reaches the outputs until a strobe passes. Two inputs turn every sink off at once without touching stored data: an output-disable input and an undervoltage input. A per-channel fault mask from a separate supervisor turns single channels off.

Top module: `sipo_sink_driver`

## Requirements
- R1: After the asynchronous active-low reset, all register stages and all latch bits are 0, so every `sink_en_n` bit is 1 (off) and `ser_out` is 0.
- R2: On each synchronized rising edge of `sh_clk`, stage 0 takes `ser_in` and every stage k moves to stage k+1. Without an edge the register holds. After eight edges, the first bit shifted sits in stage 7.
- R3: `ser_out` always equals the last register stage (stage 7).
- R4: While `clr` is high at a shift edge, stage 0 takes a 0 instead of `ser_in`, and the other stages shift as normal.
- R5: Clear never changes the output latch. Bits that were cleared only turn channels off after a strobe.
- R6: While the synchronized `stb` is high, the latch is transparent. It follows each change of the register one system clock later.
- R7: While the synchronized `stb` is low, the latch holds its value, even as new data is shifted in.
- R8: While `out_dis` is high, every `sink_en_n` bit is 1. Latch and register contents are unchanged, and the outputs return to the latched pattern when `out_dis` goes low.
- R9: A high `uv` input has exactly the same effect as a high `out_dis`.
- R10: A 1 in `fault_mask[i]` forces `sink_en_n[i]` to 1 and leaves the other channels alone.
- R11: Output encoding: `sink_en_n[i]` is 0 (sink on) exactly when latch bit i is 1, `out_dis` and `uv` are low, and `fault_mask[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_in | input | 1 | Serial data bit |
| sh_clk | input | 1 | Shift clock (asynchronous); its rising edge shifts the register |
| clr | input | 1 | Shift zeros instead of serial data while high |
| stb | input | 1 | Strobe (asynchronous); latch is transparent while high |
| out_dis | input | 1 | Forces all sinks off while high |
| uv | input | 1 | Undervoltage indication; acts like out_dis |
| fault_mask | input | CHANNELS | Per-channel fault shutdown from a supervisor, 1 = force off |
| ser_out | output | 1 | Last register stage, for cascading |
| sink_en_n | output | CHANNELS | Active-low sink enables, 0 = sink conducting |

## Verification
The bench builds the block with its defaults: eight channels and two synchronizer stages. At that size, every one of the 256 register patterns can be shifted in and strobed out. This means each stage position and both bit values are exercised, in both latch-hold and strobe phases. All 256 fault-mask values are also applied against a full latch. The clear, transparent-strobe, disable and undervoltage cases are each run with a known latched pattern, so any disturbance of stored data shows up at the outputs after the gating is released.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    parameter int unsigned DEF_CHANNELS    = 8;
    parameter int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
    parameter int unsigned STAGES = sipo_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb pipe_d = async_in;
        end else begin : g_many
            always_comb pipe_d = {pipe_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign level = pipe_q[STAGES-1];
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned CHANNELS = sipo_pkg::DEF_CHANNELS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_lvl,
    input  logic                din,
    input  logic                clr,
    output logic [CHANNELS-1:0] bits
);
    typedef struct packed {
        logic [CHANNELS-1:0] bits;
        logic                sclk_prev;
    } chain_t;

    chain_t st_d, st_q;
    logic   step;

    always_comb begin
        st_d           = st_q;
        step           = sclk_lvl & ~st_q.sclk_prev;
        st_d.sclk_prev = sclk_lvl;
        if (step) begin
            st_d.bits = {st_q.bits[CHANNELS-2:0], din & ~clr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.bits;

    // R2
    hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_lvl && !st_q.sclk_prev) |=> $stable(st_q.bits));
    // R2
    entry_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_lvl && !st_q.sclk_prev && !clr) |=> (st_q.bits[0] == $past(din)));
    // R4
    clear_enters_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_lvl && !st_q.sclk_prev && clr) |=> (st_q.bits[0] == 1'b0));
endmodule

// File: rtl/sipo_out_latch.sv
module sipo_out_latch #(
    parameter int unsigned CHANNELS = sipo_pkg::DEF_CHANNELS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                open,
    input  logic [CHANNELS-1:0] src,
    output logic [CHANNELS-1:0] held
);
    logic [CHANNELS-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (open) held_d = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign held = held_q;

    // R7
    closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(held_q));
    // R6
    open_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open |=> (held_q == $past(src)));
endmodule

// File: rtl/sipo_sink_driver.sv
module sipo_sink_driver #(
    parameter int unsigned CHANNELS    = sipo_pkg::DEF_CHANNELS,
    parameter int unsigned SYNC_STAGES = sipo_pkg::DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                sh_clk,
    input  logic                clr,
    input  logic                stb,
    input  logic                out_dis,
    input  logic                uv,
    input  logic [CHANNELS-1:0] fault_mask,
    output logic                ser_out,
    output logic [CHANNELS-1:0] sink_en_n
);
    localparam int unsigned LAST = CHANNELS - 1;

    logic                sclk_lvl, stb_lvl, kill_all;
    logic [CHANNELS-1:0] chain_bits, latch_bits, sink_on;

    sipo_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sh_clk), .level(sclk_lvl)
    );

    sipo_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .async_in(stb), .level(stb_lvl)
    );

    sipo_shift_chain #(.CHANNELS(CHANNELS)) u_chain (
        .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl),
        .din(ser_in), .clr(clr), .bits(chain_bits)
    );

    sipo_out_latch #(.CHANNELS(CHANNELS)) u_latch (
        .clk(clk), .rst_n(rst_n), .open(stb_lvl),
        .src(chain_bits), .held(latch_bits)
    );

    always_comb begin
        kill_all = out_dis | uv;
        sink_on  = latch_bits & ~fault_mask & {CHANNELS{~kill_all}};
    end

    assign sink_en_n = ~sink_on;
    assign ser_out   = chain_bits[LAST];

    // R8
    disable_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> (sink_en_n == {CHANNELS{1'b1}}));
    // R9
    uv_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv |-> (sink_en_n == {CHANNELS{1'b1}}));
    // R10
    masked_channel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sink_en_n & fault_mask) == '0));
endmodule

// File: tb/sim_sipo_sink_driver.sv
module sim_sipo_sink_driver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0, sh_clk = 1'b0, clr = 1'b0, stb = 1'b0;
    logic       out_dis = 1'b0, uv = 1'b0;
    logic [7:0] fault_mask = 8'h00;
    logic       ser_out;
    logic [7:0] sink_en_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl = 8'h00;
    logic [7:0] lat = 8'h00;

    always #4 clk = ~clk;

    sipo_sink_driver u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sh_clk(sh_clk), .clr(clr),
        .stb(stb), .out_dis(out_dis), .uv(uv), .fault_mask(fault_mask),
        .ser_out(ser_out), .sink_en_n(sink_en_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_one(input logic b, input logic c);
        @(negedge clk);
        ser_in = b; clr = c; sh_clk = 1'b1;
        wait_n(4);
        sh_clk = 1'b0;
        wait_n(4);
        mdl = {mdl[6:0], b & ~c};
        clr = 1'b0;
    endtask

    task automatic strobe_pulse();
        @(negedge clk);
        stb = 1'b1;
        wait_n(5);
        stb = 1'b0;
        wait_n(4);
        lat = mdl;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 00 expected 01");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        // R1 reset state
        chk("R1 sinks", sink_en_n, 8'hFF);
        chk("R1 ser_out", {7'd0, ser_out}, 8'h00);
        rst_n = 1'b1;
        wait_n(2);

        // R2 R3 R7 R11 exhaustive pattern sweep
        for (int p = 0; p < 256; p++) begin
            for (int k = 7; k >= 0; k--) begin
                shift_one(p[k], 1'b0);
                chk("R3 ser_out", {7'd0, ser_out}, {7'd0, mdl[7]});
                chk("R7 hold", sink_en_n, ~lat);
            end
            strobe_pulse();
            chk("R2 pattern", sink_en_n, ~p[7:0]);
        end

        // R4 R5 clear shifts zeros, latch untouched
        for (int k = 0; k < 8; k++) shift_one(1'b1, 1'b0);
        strobe_pulse();
        chk("R11 all on", sink_en_n, 8'h00);
        shift_one(1'b1, 1'b1);
        shift_one(1'b1, 1'b0);
        shift_one(1'b1, 1'b1);
        chk("R5 no strobe", sink_en_n, 8'h00);
        strobe_pulse();
        chk("R4 cleared", sink_en_n, 8'h05);
        for (int k = 0; k < 8; k++) shift_one(1'b1, 1'b1);
        chk("R4 ser_out", {7'd0, ser_out}, 8'h00);
        chk("R5 latch kept", sink_en_n, 8'h05);
        strobe_pulse();
        chk("R4 all off", sink_en_n, 8'hFF);

        // R6 transparent strobe
        @(negedge clk);
        stb = 1'b1;
        wait_n(4);
        for (int k = 0; k < 8; k++) begin
            shift_one(k[0], 1'b0);
            chk("R6 follow", sink_en_n, ~mdl);
        end
        stb = 1'b0;
        wait_n(4);
        lat = mdl;

        // R8 R9 gating with data unchanged
        fault_mask = 8'h00;
        @(negedge clk); out_dis = 1'b1; #1;
        chk("R8 off", sink_en_n, 8'hFF);
        wait_n(3);
        out_dis = 1'b0; #1;
        chk("R8 restore", sink_en_n, ~lat);
        @(negedge clk); uv = 1'b1; #1;
        chk("R9 off", sink_en_n, 8'hFF);
        shift_one(1'b1, 1'b0);
        chk("R9 ser_out", {7'd0, ser_out}, {7'd0, mdl[7]});
        uv = 1'b0; #1;
        chk("R9 restore", sink_en_n, ~lat);

        // R10 fault mask sweep on full latch
        for (int k = 0; k < 8; k++) shift_one(1'b1, 1'b0);
        strobe_pulse();
        for (int m = 0; m < 256; m++) begin
            @(negedge clk);
            fault_mask = m[7:0]; #1;
            chk("R10 mask", sink_en_n, ~(lat & ~m[7:0]));
        end
        out_dis = 1'b1; #1;
        chk("R11 dis+mask", sink_en_n, 8'hFF);
        out_dis = 1'b0;
        fault_mask = 8'h00; #1;
        chk("R11 final", sink_en_n, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule